// File: doc/BRIEF.md
# Per-Destination Keyed Flit Cipher Link Endpoint

This block sits where a node meets a shared multi-drop link. On the transmit side it accepts one wide flit together with a destination index. It then looks up a secret key for that destination in a local table, and combines the key with the whole flit by XOR in a single cycle. The masked flit goes onto the link as a burst of narrow beats on consecutive cycles. Every destination has its own key. The sending node holds the keys of all destinations it can reach, so a listener on the link that is not the addressee cannot unmask traffic meant for another node.

On the receive side the same block gathers beats from the link into a full flit. It unmasks the flit with the one key that belongs to this node, in a single cycle, and presents the plain flit on a valid/ready port. One load port writes the sender key table and the node's own receive key, and a select input chooses which of the two is written. Key generation and link arbitration are outside this block.

Top module: `flit_xor_link`

## Requirements
- R1: After reset, tx_ready is 1, link_out_vld is 0 and rx_valid is 0.
- R2: A flit is taken on a clock edge where tx_valid and tx_ready are both 1. For an in-range destination, tx_ready then stays 0 for nine cycles: one masking cycle and eight beat cycles. It returns to 1 in the cycle after the last beat.
- R3: The cycle right after acceptance is the masking cycle, and no beat is driven in it. The eight beats follow on the eight cycles after it with no gaps, with link_out_vld at 1 on each of them.
- R4: Beat k (k = 0..7) carries bits 64k+63 down to 64k of (flit XOR key). Beat 0 holds the least significant 64 bits.
- R5: The key used is the sender table entry whose index equals tx_dest at acceptance. A load with key_ld_en=1 and key_ld_own=0 replaces table entry key_ld_idx, and flits taken after the load use the new value.
- R6: When NUM_DEST is not a power of two, a destination index of NUM_DEST or more is accepted and discarded. No beat is driven, and tx_ready is 0 for exactly one cycle. A table load to such an index leaves every valid entry unchanged.
- R7: After the eighth beat marked by link_in_vld, rx_valid rises in the next cycle, and rx_flit equals (the collected beats, beat 0 in the low bits) XOR the own receive key. rx_valid stays 0 while a flit is only partly collected.
- R8: While rx_valid is 1 and rx_ready is 0, rx_valid and rx_flit hold their values. After a cycle with rx_ready=1, rx_valid drops, unless a new flit completes in that same cycle.
- R9: A load with key_ld_en=1 and key_ld_own=1 replaces only the own receive key. It has no effect on the sender key table.
- R10: Receive beats need not be on consecutive cycles. Only cycles with link_in_vld=1 count, and idle cycles between beats do not change the collected flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_ld_en | input | 1 | Key load strobe |
| key_ld_own | input | 1 | 1: load the own receive key; 0: load a sender table entry |
| key_ld_idx | input | IDX_W | Sender table entry to load |
| key_ld_data | input | FLIT_W | Key value to load |
| tx_valid | input | 1 | Transmit flit offered |
| tx_ready | output | 1 | Transmit side can take a flit |
| tx_flit | input | FLIT_W | Plain flit to send |
| tx_dest | input | IDX_W | Destination index selecting the key |
| link_out_vld | output | 1 | Outgoing beat valid |
| link_out_data | output | BEAT_W | Outgoing masked beat |
| link_in_vld | input | 1 | Incoming beat valid |
| link_in_data | input | BEAT_W | Incoming masked beat |
| rx_valid | output | 1 | Unmasked flit available |
| rx_ready | input | 1 | Consumer takes the flit |
| rx_flit | output | FLIT_W | Unmasked received flit |

## Verification
The assertions check the handshake timing on every cycle. They confirm that acceptance drops ready and produces no beat in the masking cycle, that a burst runs unbroken and ends with ready returning, that the eighth received beat raises rx_valid, and that a waiting output flit stays stable. The bench scenarios cover the data path: each beat's bit slice against the per-destination key, the choice of key by destination, key reloads, the separation of the own key from the sender table, discarding of out-of-range indices, and assembly across idle gaps.

// File: rtl/flit_xor_pkg.sv
package flit_xor_pkg;
   typedef enum logic [1:0] {
      TX_IDLE = 2'd0,
      TX_MASK = 2'd1,
      TX_SEND = 2'd2
   } tx_state_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/dest_key_table.sv
module dest_key_table #(
   parameter int FLIT_W   = 512,
   parameter int NUM_DEST = 16,
   parameter int IDX_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [FLIT_W-1:0] wr_key,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [FLIT_W-1:0] rd_key,
   output logic              rd_hit
);
   localparam bit FULL_RANGE = ((1 << IDX_W) == NUM_DEST);

   logic [FLIT_W-1:0] entry_q [NUM_DEST];

   for (genvar e = 0; e < NUM_DEST; e++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            entry_q[e] <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(e))) begin
            entry_q[e] <= wr_key;
         end
      end
   end

   always_comb begin
      rd_key = '0;
      for (int e = 0; e < NUM_DEST; e++) begin
         if (rd_idx == IDX_W'(e)) rd_key = entry_q[e];
      end
   end

   if (FULL_RANGE) begin : g_full
      assign rd_hit = 1'b1;
   end else begin : g_partial
      assign rd_hit = (32'(rd_idx) < NUM_DEST);
   end
endmodule

// File: rtl/tx_mask_serializer.sv
module tx_mask_serializer
   import flit_xor_pkg::*;
#(
   parameter int FLIT_W = 512,
   parameter int BEAT_W = 64,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_valid,
   output logic              tx_ready,
   input  logic [FLIT_W-1:0] tx_flit,
   input  logic [IDX_W-1:0]  tx_dest,
   output logic [IDX_W-1:0]  key_idx,
   input  logic [FLIT_W-1:0] key,
   input  logic              key_hit,
   output logic              link_vld,
   output logic [BEAT_W-1:0] link_data
);
   localparam int BEATS = FLIT_W / BEAT_W;
   localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

   tx_state_e         state_q;
   logic [FLIT_W-1:0] flit_q;
   logic [IDX_W-1:0]  dest_q;
   logic [FLIT_W-1:0] shift_q;
   logic [CNT_W-1:0]  cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= TX_IDLE;
         flit_q  <= '0;
         dest_q  <= '0;
         shift_q <= '0;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            TX_IDLE: if (tx_valid) begin
               flit_q  <= tx_flit;
               dest_q  <= tx_dest;
               state_q <= TX_MASK;
            end
            TX_MASK: begin
               cnt_q <= '0;
               if (key_hit) begin
                  shift_q <= flit_q ^ key;
                  state_q <= TX_SEND;
               end else begin
                  state_q <= TX_IDLE;
               end
            end
            TX_SEND: begin
               shift_q <= shift_q >> BEAT_W;
               cnt_q   <= cnt_q + 1'b1;
               if (cnt_q == LAST) state_q <= TX_IDLE;
            end
            default: state_q <= TX_IDLE;
         endcase
      end
   end

   assign tx_ready  = (state_q == TX_IDLE);
   assign key_idx   = dest_q;
   assign link_vld  = (state_q == TX_SEND);
   assign link_data = shift_q[BEAT_W-1:0];

   p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && tx_ready |=> !tx_ready);
   p_mask_cycle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && tx_ready |=> !link_vld);
   p_burst_unbroken_r3: assert property (@(posedge clk) disable iff (!rst_n)
      link_vld && (cnt_q != LAST) |=> link_vld && !tx_ready);
   p_burst_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
      link_vld && (cnt_q == LAST) |=> tx_ready && !link_vld);
endmodule

// File: rtl/rx_unmask_deframer.sv
module rx_unmask_deframer #(
   parameter int FLIT_W = 512,
   parameter int BEAT_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_wr_en,
   input  logic [FLIT_W-1:0] key_wr,
   input  logic              link_vld,
   input  logic [BEAT_W-1:0] link_data,
   output logic              rx_valid,
   input  logic              rx_ready,
   output logic [FLIT_W-1:0] rx_flit
);
   localparam int BEATS = FLIT_W / BEAT_W;
   localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

   logic [FLIT_W-1:0] own_key_q;
   logic [FLIT_W-1:0] gather_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [FLIT_W-1:0] gathered;
   logic              complete;

   assign gathered = {link_data, gather_q[FLIT_W-1:BEAT_W]};
   assign complete = link_vld && (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         own_key_q <= '0;
         gather_q  <= '0;
         cnt_q     <= '0;
         rx_valid  <= 1'b0;
         rx_flit   <= '0;
      end else begin
         if (key_wr_en) own_key_q <= key_wr;
         if (link_vld) begin
            gather_q <= gathered;
            cnt_q    <= complete ? '0 : cnt_q + 1'b1;
         end
         if (complete) begin
            rx_valid <= 1'b1;
            rx_flit  <= gathered ^ own_key_q;
         end else if (rx_ready) begin
            rx_valid <= 1'b0;
         end
      end
   end

   p_complete_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      complete |=> rx_valid);
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && !rx_ready && !complete |=> rx_valid && $stable(rx_flit));
   p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && rx_ready && !complete |=> !rx_valid);
endmodule

// File: rtl/flit_xor_link.sv
module flit_xor_link
   import flit_xor_pkg::*;
#(
   parameter int FLIT_W   = 512,
   parameter int BEAT_W   = 64,
   parameter int NUM_DEST = 16,
   parameter int IDX_W    = idx_width(NUM_DEST)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_ld_en,
   input  logic              key_ld_own,
   input  logic [IDX_W-1:0]  key_ld_idx,
   input  logic [FLIT_W-1:0] key_ld_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   input  logic [FLIT_W-1:0] tx_flit,
   input  logic [IDX_W-1:0]  tx_dest,
   output logic              link_out_vld,
   output logic [BEAT_W-1:0] link_out_data,
   input  logic              link_in_vld,
   input  logic [BEAT_W-1:0] link_in_data,
   output logic              rx_valid,
   input  logic              rx_ready,
   output logic [FLIT_W-1:0] rx_flit
);
   if ((FLIT_W % BEAT_W) != 0 || (FLIT_W / BEAT_W) < 2) begin : g_bad_width
      $error("FLIT_W must be a multiple of BEAT_W with at least two beats");
   end
   if (NUM_DEST < 2 || NUM_DEST > 64) begin : g_bad_dest
      $error("NUM_DEST must lie between 2 and 64");
   end
   if (IDX_W < idx_width(NUM_DEST)) begin : g_bad_idx
      $error("IDX_W too narrow for NUM_DEST");
   end

   logic [IDX_W-1:0]  key_idx;
   logic [FLIT_W-1:0] key;
   logic              key_hit;

   dest_key_table #(
      .FLIT_W(FLIT_W), .NUM_DEST(NUM_DEST), .IDX_W(IDX_W)
   ) u_table (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (key_ld_en && !key_ld_own),
      .wr_idx (key_ld_idx),
      .wr_key (key_ld_data),
      .rd_idx (key_idx),
      .rd_key (key),
      .rd_hit (key_hit)
   );

   tx_mask_serializer #(
      .FLIT_W(FLIT_W), .BEAT_W(BEAT_W), .IDX_W(IDX_W)
   ) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_valid  (tx_valid),
      .tx_ready  (tx_ready),
      .tx_flit   (tx_flit),
      .tx_dest   (tx_dest),
      .key_idx   (key_idx),
      .key       (key),
      .key_hit   (key_hit),
      .link_vld  (link_out_vld),
      .link_data (link_out_data)
   );

   rx_unmask_deframer #(
      .FLIT_W(FLIT_W), .BEAT_W(BEAT_W)
   ) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .key_wr_en (key_ld_en && key_ld_own),
      .key_wr    (key_ld_data),
      .link_vld  (link_in_vld),
      .link_data (link_in_data),
      .rx_valid  (rx_valid),
      .rx_ready  (rx_ready),
      .rx_flit   (rx_flit)
   );
endmodule

// File: tb/flit_xor_link_test.sv
`timescale 1ns/1ps
module flit_xor_link_test;
   localparam int FW = 512;
   localparam int BW = 64;
   localparam int ND = 7;
   localparam int IW = 3;
   localparam int NB = FW / BW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          key_ld_en = 1'b0, key_ld_own = 1'b0;
   logic [IW-1:0] key_ld_idx = '0;
   logic [FW-1:0] key_ld_data = '0;
   logic          tx_valid = 1'b0;
   logic          tx_ready;
   logic [FW-1:0] tx_flit = '0;
   logic [IW-1:0] tx_dest = '0;
   logic          link_out_vld;
   logic [BW-1:0] link_out_data;
   logic          loop = 1'b1;
   logic          m_vld = 1'b0;
   logic [BW-1:0] m_data = '0;
   logic          lin_vld;
   logic [BW-1:0] lin_data;
   logic          rx_valid;
   logic          rx_ready = 1'b0;
   logic [FW-1:0] rx_flit;

   int errors = 0;
   int checks = 0;
   logic [FW-1:0] tkey [ND];
   logic [FW-1:0] own;

   assign lin_vld  = loop ? link_out_vld  : m_vld;
   assign lin_data = loop ? link_out_data : m_data;

   always #2 clk = ~clk;

   flit_xor_link #(.FLIT_W(FW), .BEAT_W(BW), .NUM_DEST(ND)) uut (
      .clk(clk), .rst_n(rst_n),
      .key_ld_en(key_ld_en), .key_ld_own(key_ld_own),
      .key_ld_idx(key_ld_idx), .key_ld_data(key_ld_data),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_flit(tx_flit), .tx_dest(tx_dest),
      .link_out_vld(link_out_vld), .link_out_data(link_out_data),
      .link_in_vld(lin_vld), .link_in_data(lin_data),
      .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_flit(rx_flit)
   );

   function automatic logic [FW-1:0] mk(input int s);
      logic [FW-1:0] r;
      for (int j = 0; j < NB; j++)
         r[j*BW +: BW] = ((64'(s) + 64'd1) * 64'h9E3779B97F4A7C15) ^ (64'(j) << 40) ^ 64'(s * 7 + j);
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic load(input bit own_sel, input int idx, input logic [FW-1:0] k);
      @(negedge clk);
      key_ld_en = 1'b1; key_ld_own = own_sel; key_ld_idx = IW'(idx); key_ld_data = k;
      @(negedge clk);
      key_ld_en = 1'b0; key_ld_own = 1'b0;
   endtask

   task automatic send(input int d, input logic [FW-1:0] f);
      logic [FW-1:0] enc;
      enc = f ^ tkey[d];
      @(negedge clk);
      chk(tx_ready == 1'b1, "R2 ready before accept", FW'(tx_ready), FW'(1));
      tx_valid = 1'b1; tx_dest = IW'(d); tx_flit = f;
      @(negedge clk);
      tx_valid = 1'b0;
      chk(tx_ready == 1'b0, "R2 ready low in masking cycle", FW'(tx_ready), FW'(0));
      chk(link_out_vld == 1'b0, "R3 no beat in masking cycle", FW'(link_out_vld), FW'(0));
      for (int k = 0; k < NB; k++) begin
         @(negedge clk);
         chk(link_out_vld == 1'b1, "R3 beat valid", FW'(link_out_vld), FW'(1));
         chk(link_out_data == enc[k*BW +: BW], "R4/R5 beat data", FW'(link_out_data), FW'(enc[k*BW +: BW]));
         chk(tx_ready == 1'b0, "R2 ready low during burst", FW'(tx_ready), FW'(0));
         chk(rx_valid == 1'b0, "R7 no output mid-flit", FW'(rx_valid), FW'(0));
      end
      @(negedge clk);
      chk(tx_ready == 1'b1 && link_out_vld == 1'b0, "R2 ready back after last beat",
          FW'({tx_ready, link_out_vld}), FW'(2'b10));
      chk(rx_valid == 1'b1, "R7 rx_valid after eighth beat", FW'(rx_valid), FW'(1));
      chk(rx_flit == (enc ^ own), "R7 unmasked flit", rx_flit, enc ^ own);
      @(negedge clk);
      chk(rx_valid == 1'b1 && rx_flit == (enc ^ own), "R8 hold while not ready", rx_flit, enc ^ own);
      rx_ready = 1'b1;
      @(negedge clk);
      rx_ready = 1'b0;
      chk(rx_valid == 1'b0, "R8 drop after take", FW'(rx_valid), FW'(0));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(tx_ready == 1'b1, "R1 tx_ready", FW'(tx_ready), FW'(1));
      chk(link_out_vld == 1'b0, "R1 link_out_vld", FW'(link_out_vld), FW'(0));
      chk(rx_valid == 1'b0, "R1 rx_valid", FW'(rx_valid), FW'(0));

      for (int e = 0; e < ND; e++) begin
         tkey[e] = mk(e + 11);
         load(1'b0, e, tkey[e]);
      end
      load(1'b0, 7, mk(99));   // R6 out-of-range load ignored
      own = mk(500);
      load(1'b1, 0, own);      // R9 own key only

      // R4 R5 sweep over every destination and three patterns
      for (int d = 0; d < ND; d++) begin
         send(d, '0);
         send(d, '1);
         send(d, mk(1000 + d));
      end

      // R5 reload one entry; neighbour unchanged
      tkey[3] = mk(77);
      load(1'b0, 3, tkey[3]);
      send(3, mk(2000));
      send(4, mk(2001));

      // R9 new own key leaves sender table intact
      own = mk(600);
      load(1'b1, 2, own);
      send(2, mk(2002));

      // R6 out-of-range destination discarded
      @(negedge clk);
      tx_valid = 1'b1; tx_dest = 3'd7; tx_flit = mk(3000);
      @(negedge clk);
      tx_valid = 1'b0;
      chk(tx_ready == 1'b0 && link_out_vld == 1'b0, "R6 one busy cycle",
          FW'({tx_ready, link_out_vld}), FW'(2'b00));
      for (int i = 0; i < NB + 2; i++) begin
         @(negedge clk);
         chk(tx_ready == 1'b1 && link_out_vld == 1'b0 && rx_valid == 1'b0, "R6 no beats after discard",
             FW'({tx_ready, link_out_vld, rx_valid}), FW'(3'b100));
      end

      // R10 receive with idle gaps
      loop = 1'b0;
      begin
         logic [FW-1:0] g;
         g = mk(4000);
         for (int k = 0; k < NB; k++) begin
            @(negedge clk);
            m_vld = 1'b1; m_data = g[k*BW +: BW];
            @(negedge clk);
            m_vld = 1'b0; m_data = '1;
            if (k < NB - 1) begin
               chk(rx_valid == 1'b0, "R10 no output before eighth beat", FW'(rx_valid), FW'(0));
               repeat (k % 3) @(negedge clk);
            end
         end
         chk(rx_valid == 1'b1 && rx_flit == (g ^ own), "R10 gapped flit unmasked", rx_flit, g ^ own);
         rx_ready = 1'b1;
         @(negedge clk);
         rx_ready = 1'b0;
         chk(rx_valid == 1'b0, "R8 drop after gapped take", FW'(rx_valid), FW'(0));
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule